// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block drives an I2C bus as its only master. Software does not hand it a whole transfer. It issues one bus step at a time by setting a bit in a five-bit command write: Start, Repeated Start, Stop, receive one byte, or send the acknowledge bit. The bit stays visible while that step runs and clears itself when the step completes. Writing the transmit byte starts an eight-bit send followed by a ninth clock that samples the slave's acknowledge. The bus lines are open-drain. The block outputs pull-low enables for SCL and SDA, and it reads the SDA pad through a synchronizer.

The timing comes from a reload value. Every step is built from phases, and each phase holds the lines for `div_reload + 1` clocks. The states are S_IDLE, S_RS_PREP, S_ST_SETUP, S_ST_HOLD, S_ST_LOW, S_SP_LOW, S_SP_SCLH, S_SP_SDAH, S_BIT_LOW, S_BIT_HIGH and S_BIT_TAIL.

- An accepted command leaves S_IDLE for S_ST_SETUP (Start), S_RS_PREP (Repeated Start), S_SP_LOW (Stop) or S_BIT_LOW (transmit, receive, acknowledge). Every other transition fires at the end of a phase.
- The Start path runs S_RS_PREP→S_ST_SETUP→S_ST_HOLD→S_ST_LOW→S_IDLE.
- The Stop path runs S_SP_LOW→S_SP_SCLH→S_SP_SDAH→S_IDLE.
- The bit path runs S_BIT_LOW→S_BIT_HIGH. From S_BIT_HIGH it returns to S_BIT_LOW, or it goes to S_BIT_TAIL after the last bit. S_BIT_TAIL then returns to S_IDLE.
- Entering S_IDLE raises the one-cycle done pulse.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset both pull-low enables are 0, and busy, done, cmd_active, rx_byte and slave_nack are all 0.
- R2: Each bus phase lasts exactly div_reload+1 clocks. busy is high from the clock after acceptance until the last phase ends. done is high for exactly the one clock in which busy first reads 0. A new command issued in that done clock is accepted.
- R3: ctl_bits bit 0 (Start) produces three phases as (scl_oe,sda_oe) pairs: (0,0), then (0,1), then (1,1).
- R4: ctl_bits bit 1 (Repeated Start) produces four phases: (1,0), then the three Start phases.
- R5: ctl_bits bit 2 (Stop) produces three phases: (1,1), then (0,1), then (0,0).
- R6: A tx_wr sends tx_byte MSB first. Each bit has a low phase and a high phase, and sda_oe equals the inverted bit in both. The ninth bit releases SDA. At the end of its high phase slave_nack takes the synchronized SDA level (1 = NACK). A low tail phase follows with SDA released.
- R7: ctl_bits bit 3 (receive) clocks eight bits with SDA released and samples each bit at the end of its high phase, MSB first. rx_byte updates when the eighth bit is sampled. A low tail phase follows.
- R8: ctl_bits bit 4 (acknowledge) runs a low phase, a high phase and a low tail phase. sda_oe is 1 in all three when ack_level is 0 (ACK) and 0 when ack_level is 1 (NACK). ack_level is captured when the command is accepted.
- R9: While busy, ctl_wr and tx_wr are ignored. The line sequence, cmd_active and the step's results are unchanged.
- R10: In a single idle write the lowest set ctl_bits bit wins. A ctl_wr with any bit set wins over tx_wr in the same clock. A ctl_wr with no bit set does not block a simultaneous tx_wr.
- R11: cmd_active is one-hot while a step runs (bits 0 to 4 mirror ctl_bits, bit 5 is transmit) and reads 0 in the done clock.
- R12: Between steps the lines hold their final state. After Start or Repeated Start the hold is (1,1). After a byte, receive or acknowledge it is (1,0). After Stop it is (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Command write strobe |
| ctl_bits | input | 5 | Command bits: 0 Start, 1 Repeated Start, 2 Stop, 3 receive, 4 acknowledge |
| ack_level | input | 1 | Acknowledge value to send: 0 ACK, 1 NACK |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_byte | input | 8 | Byte to send |
| div_reload | input | 16 | Phase length minus one, in clocks |
| sda_in | input | 1 | SDA pad level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| busy | output | 1 | A step is running |
| done | output | 1 | One-clock completion pulse |
| cmd_active | output | 6 | One-hot running step |
| rx_byte | output | 8 | Last received byte |
| slave_nack | output | 1 | Acknowledge sampled after a send (1 = NACK) |

## Verification
Two events can fall in the same clock. The first is the done pulse of a finishing step together with a write of the next command. The bench provokes this by issuing the next command in the done clock. It then checks that the following step starts at once, with no extra idle clock.

The second collision is a command write together with a transmit write, or with a second command bit. The bench applies these writes in one clock and checks that only the winning step's line sequence appears. The bench also makes writes while a step is busy, and the clock-by-clock comparison shows that nothing in the running step changed.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    localparam int CMD_BITS = 5;
    localparam int OP_COUNT = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RS_PREP,
        S_ST_SETUP,
        S_ST_HOLD,
        S_ST_LOW,
        S_SP_LOW,
        S_SP_SCLH,
        S_SP_SDAH,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_BIT_TAIL
    } eng_state_e;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_STOP   = 3'd2,
        OP_RECV   = 3'd3,
        OP_ACK    = 3'd4,
        OP_SEND   = 3'd5
    } eng_op_e;
endpackage

// File: rtl/i2c_pad_sync.sv
module i2c_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic pad_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], pad_in};
        end
    end

    assign pad_sync = chain[STAGES-1];
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= reload;
        end else if (run) begin
            if (cnt == '0) cnt <= reload;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              last,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data_out
);
    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            data_out <= '0;
        end else if (sample) begin
            shreg <= {shreg[DATA_W-2:0], bit_in};
            if (last) data_out <= {shreg[DATA_W-2:0], bit_in};
        end
    end
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
    import i2c_cmd_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [CMD_BITS-1:0] ctl_bits,
    input  logic                ack_level,
    input  logic                tx_wr,
    input  logic [DATA_W-1:0]   tx_byte,
    input  logic [DIV_W-1:0]    div_reload,
    input  logic                sda_in,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic                busy,
    output logic                done,
    output logic [OP_COUNT-1:0] cmd_active,
    output logic [DATA_W-1:0]   rx_byte,
    output logic                slave_nack
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    eng_state_e        state, nxt;
    eng_op_e           op, pick_op;
    logic              pick_ok, accept, tick, finish, sda_s, drv, at_last;
    logic [IDX_W-1:0]  idx, last_idx;
    logic [DATA_W-1:0] txbuf;
    logic              ack_q, hold_scl, hold_sda;

    i2c_pad_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_in(sda_in), .pad_sync(sda_s)
    );

    i2c_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
        .reload(div_reload), .tick(tick)
    );

    i2c_rx_shift #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .sample(tick && state == S_BIT_HIGH && op == OP_RECV),
        .last(at_last), .bit_in(sda_s), .data_out(rx_byte)
    );

    // command pick: lowest set bit wins, any command bit beats a byte write
    always_comb begin
        pick_ok = 1'b0;
        pick_op = OP_SEND;
        if (ctl_wr) begin
            for (int i = CMD_BITS - 1; i >= 0; i--) begin
                if (ctl_bits[i]) begin
                    pick_ok = 1'b1;
                    pick_op = eng_op_e'(3'(i));
                end
            end
        end
        if (!pick_ok && tx_wr) begin
            pick_ok = 1'b1;
            pick_op = OP_SEND;
        end
    end

    assign accept = (state == S_IDLE) && pick_ok;
    assign busy   = (state != S_IDLE);

    always_comb begin
        unique case (op)
            OP_SEND: last_idx = IDX_W'(DATA_W);
            OP_RECV: last_idx = IDX_W'(DATA_W - 1);
            default: last_idx = '0;
        endcase
    end
    assign at_last = (idx == last_idx);

    assign finish = tick && (state == S_ST_LOW || state == S_SP_SDAH || state == S_BIT_TAIL);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    unique case (pick_op)
                        OP_START:  nxt = S_ST_SETUP;
                        OP_RSTART: nxt = S_RS_PREP;
                        OP_STOP:   nxt = S_SP_LOW;
                        default:   nxt = S_BIT_LOW;
                    endcase
                end
            end
            S_RS_PREP:  if (tick) nxt = S_ST_SETUP;
            S_ST_SETUP: if (tick) nxt = S_ST_HOLD;
            S_ST_HOLD:  if (tick) nxt = S_ST_LOW;
            S_ST_LOW:   if (tick) nxt = S_IDLE;
            S_SP_LOW:   if (tick) nxt = S_SP_SCLH;
            S_SP_SCLH:  if (tick) nxt = S_SP_SDAH;
            S_SP_SDAH:  if (tick) nxt = S_IDLE;
            S_BIT_LOW:  if (tick) nxt = S_BIT_HIGH;
            S_BIT_HIGH: if (tick) nxt = at_last ? S_BIT_TAIL : S_BIT_LOW;
            S_BIT_TAIL: if (tick) nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // step registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op         <= OP_START;
            idx        <= '0;
            txbuf      <= '0;
            ack_q      <= 1'b0;
            hold_scl   <= 1'b0;
            hold_sda   <= 1'b0;
            done       <= 1'b0;
            slave_nack <= 1'b0;
            cmd_active <= '0;
        end else begin
            done <= finish;
            if (accept) begin
                op    <= pick_op;
                idx   <= '0;
                ack_q <= ack_level;
                if (pick_op == OP_SEND) txbuf <= tx_byte;
                cmd_active          <= '0;
                cmd_active[pick_op] <= 1'b1;
            end
            if (tick && state == S_BIT_HIGH) begin
                if (!at_last) idx <= idx + 1'b1;
                if (op == OP_SEND) begin
                    txbuf <= {txbuf[DATA_W-2:0], 1'b1};
                    if (at_last) slave_nack <= sda_s;
                end
            end
            if (finish) begin
                cmd_active <= '0;
                unique case (op)
                    OP_START, OP_RSTART: begin hold_scl <= 1'b1; hold_sda <= 1'b1; end
                    OP_STOP:             begin hold_scl <= 1'b0; hold_sda <= 1'b0; end
                    default:             begin hold_scl <= 1'b1; hold_sda <= 1'b0; end
                endcase
            end
        end
    end

    // line outputs
    always_comb begin
        unique case (op)
            OP_SEND: drv = !txbuf[DATA_W-1];
            OP_ACK:  drv = !ack_q;
            default: drv = 1'b0;
        endcase
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            S_IDLE:     begin scl_oe = hold_scl; sda_oe = hold_sda; end
            S_RS_PREP:  begin scl_oe = 1'b1;     sda_oe = 1'b0;     end
            S_ST_SETUP: begin scl_oe = 1'b0;     sda_oe = 1'b0;     end
            S_ST_HOLD:  begin scl_oe = 1'b0;     sda_oe = 1'b1;     end
            S_ST_LOW:   begin scl_oe = 1'b1;     sda_oe = 1'b1;     end
            S_SP_LOW:   begin scl_oe = 1'b1;     sda_oe = 1'b1;     end
            S_SP_SCLH:  begin scl_oe = 1'b0;     sda_oe = 1'b1;     end
            S_SP_SDAH:  begin scl_oe = 1'b0;     sda_oe = 1'b0;     end
            S_BIT_LOW:  begin scl_oe = 1'b1;     sda_oe = drv;      end
            S_BIT_HIGH: begin scl_oe = 1'b0;     sda_oe = drv;      end
            S_BIT_TAIL: begin scl_oe = 1'b1;     sda_oe = drv;      end
            default:    begin scl_oe = 1'b0;     sda_oe = 1'b0;     end
        endcase
    end

    // assertions
    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_start_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> (cmd_active[OP_START] || cmd_active[OP_RSTART]));
    assert_stop_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> cmd_active[OP_STOP]);
    assert_sda_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BIT_HIGH && $past(state) == S_BIT_HIGH) |-> $stable(sda_oe));
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ctl_wr || tx_wr)) |=> (cmd_active == $past(cmd_active) || cmd_active == '0));
    assert_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_active));
endmodule

// File: tb/i2c_cmd_engine_tb.sv
module i2c_cmd_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [4:0] ctl_bits = '0;
    logic       ack_level = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_byte = '0;
    logic [15:0] div_reload = 16'd3;
    logic       slave_low = 1'b0;
    logic       sda_in;
    logic       scl_oe, sda_oe, busy, done, slave_nack;
    logic [5:0] cmd_active;
    logic [7:0] rx_byte;

    int total = 0;
    int bad = 0;
    int plen = 4;
    int q_scl[$];
    int q_sda[$];
    int q_slv[$];

    always #4 clk = ~clk;

    assign sda_in = !(sda_oe || slave_low);

    i2c_cmd_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_bits(ctl_bits),
        .ack_level(ack_level), .tx_wr(tx_wr), .tx_byte(tx_byte),
        .div_reload(div_reload), .sda_in(sda_in), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .busy(busy), .done(done), .cmd_active(cmd_active),
        .rx_byte(rx_byte), .slave_nack(slave_nack)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic ph(input int s, input int d, input int v);
        repeat (plen) begin
            q_scl.push_back(s);
            q_sda.push_back(d);
            q_slv.push_back(v);
        end
    endtask

    task automatic b_start();
        ph(0, 0, 0); ph(0, 1, 0); ph(1, 1, 0);
    endtask
    task automatic b_rstart();
        ph(1, 0, 0); b_start();
    endtask
    task automatic b_stop();
        ph(1, 1, 0); ph(0, 1, 0); ph(0, 0, 0);
    endtask
    task automatic b_tx(input logic [7:0] b, input int ackw);
        for (int i = 0; i < 8; i++) begin
            ph(1, int'(!b[7-i]), 0); ph(0, int'(!b[7-i]), 0);
        end
        ph(1, 0, ackw); ph(0, 0, ackw); ph(1, 0, 0);
    endtask
    task automatic b_rx(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            ph(1, 0, int'(!b[7-i])); ph(0, 0, int'(!b[7-i]));
        end
        ph(1, 0, 0);
    endtask
    task automatic b_ack(input logic a);
        ph(1, int'(!a), 0); ph(0, int'(!a), 0); ph(1, int'(!a), 0);
    endtask

    task automatic issue(input logic [4:0] bits, input logic cw, input logic tw,
                         input logic [7:0] b, input logic av);
        ctl_wr = cw; ctl_bits = bits; tx_wr = tw; tx_byte = b; ack_level = av;
    endtask

    // run the queued reference sequence, comparing on every clock
    task automatic execute(input string tag, input int poke, input logic hs, input logic hd, input int act_bit);
        int n = q_scl.size();
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) begin
                ctl_wr = 0; tx_wr = 0; ctl_bits = '0; ack_level = 0;
                chk(cmd_active == (6'b1 << act_bit), {tag, " R11"}, "cmd_active", int'(cmd_active), 1 << act_bit);
            end
            if (k == poke) begin
                ctl_wr = 1; ctl_bits = 5'b11111; tx_wr = 1; tx_byte = 8'hFF; ack_level = 1;
            end
            if (k == poke + 1) begin
                ctl_wr = 0; ctl_bits = '0; tx_wr = 0; ack_level = 0;
            end
            slave_low = (q_slv[k] != 0);
            chk(int'(scl_oe) == q_scl[k], tag, $sformatf("scl_oe cyc %0d", k), int'(scl_oe), q_scl[k]);
            chk(int'(sda_oe) == q_sda[k], tag, $sformatf("sda_oe cyc %0d", k), int'(sda_oe), q_sda[k]);
            chk(busy == 1'b1 && done == 1'b0, {tag, " R2"}, "busy/done", int'({busy, done}), 2);
        end
        @(negedge clk);
        slave_low = 0;
        chk(done == 1'b1 && busy == 1'b0, {tag, " R2"}, "done pulse", int'({busy, done}), 1);
        chk(scl_oe == hs && sda_oe == hd, {tag, " R12"}, "hold", int'({scl_oe, sda_oe}), int'({hs, hd}));
        chk(cmd_active == '0, {tag, " R11"}, "cmd_active cleared", int'(cmd_active), 0);
        q_scl.delete(); q_sda.delete(); q_slv.delete();
    endtask

    task automatic idle_chk(input int n, input logic hs, input logic hd);
        repeat (n) begin
            @(negedge clk);
            chk(busy == 0 && done == 0, "R2", "idle busy/done", int'({busy, done}), 0);
            chk(scl_oe == hs && sda_oe == hd, "R12", "idle hold", int'({scl_oe, sda_oe}), int'({hs, hd}));
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_oe == 0 && sda_oe == 0, "R1", "lines", int'({scl_oe, sda_oe}), 0);
        chk(busy == 0 && done == 0, "R1", "busy/done", int'({busy, done}), 0);
        chk(cmd_active == 0 && rx_byte == 0 && slave_nack == 0, "R1", "status", int'(cmd_active) + int'(rx_byte) + int'(slave_nack), 0);

        // R3 Start with writes while busy (R9)
        b_start(); issue(5'b00001, 1, 0, 8'h00, 0);
        execute("R3 R9", 5, 1, 1, 0);
        idle_chk(3, 1, 1);

        // R6 send with ACK, poked while busy (R9)
        b_tx(8'hA5, 1); issue(5'b00000, 0, 1, 8'hA5, 0);
        execute("R6 R9", 10, 1, 0, 5);
        chk(slave_nack == 0, "R6", "slave_nack ack", int'(slave_nack), 0);

        // R2 command issued in the done clock; R6 send with NACK
        b_tx(8'h3C, 0); issue(5'b00000, 0, 1, 8'h3C, 0);
        execute("R6 R2", -5, 1, 0, 5);
        chk(slave_nack == 1, "R6", "slave_nack nack", int'(slave_nack), 1);
        idle_chk(2, 1, 0);

        // R4 Repeated Start
        b_rstart(); issue(5'b00010, 1, 0, 8'h00, 0);
        execute("R4", -5, 1, 1, 1);
        idle_chk(2, 1, 1);

        // R7 receive
        b_rx(8'h96); issue(5'b01000, 1, 0, 8'h00, 0);
        execute("R7", -5, 1, 0, 3);
        chk(rx_byte == 8'h96, "R7", "rx_byte", int'(rx_byte), 8'h96);

        // R8 ACK
        b_ack(1'b0); issue(5'b10000, 1, 0, 8'h00, 0);
        execute("R8", -5, 1, 0, 4);

        b_rx(8'h5B); issue(5'b01000, 1, 0, 8'h00, 0);
        execute("R7", -5, 1, 0, 3);
        chk(rx_byte == 8'h5B, "R7", "rx_byte", int'(rx_byte), 8'h5B);

        // R8 NACK, level captured at accept
        b_ack(1'b1); issue(5'b10000, 1, 0, 8'h00, 1);
        execute("R8", -5, 1, 0, 4);
        idle_chk(2, 1, 0);

        // R10 Repeated Start beats Stop and byte write
        b_rstart(); issue(5'b00110, 1, 1, 8'h77, 0);
        execute("R10", -5, 1, 1, 1);

        // R10 empty command write lets byte write through
        b_tx(8'h81, 1); issue(5'b00000, 1, 1, 8'h81, 0);
        execute("R10", -5, 1, 0, 5);
        chk(slave_nack == 0, "R10", "slave_nack", int'(slave_nack), 0);

        // R5 Stop beats acknowledge
        b_stop(); issue(5'b10100, 1, 0, 8'h00, 0);
        execute("R5 R10", -5, 0, 0, 2);
        idle_chk(3, 0, 0);

        // R2 longer phases
        div_reload = 16'd5; plen = 6;
        b_start(); issue(5'b00001, 1, 0, 8'h00, 0);
        execute("R2 R3", -5, 1, 1, 0);
        b_stop(); issue(5'b00100, 1, 0, 8'h00, 0);
        execute("R2 R5", -5, 0, 0, 2);
        idle_chk(2, 0, 0);

        summary();
        $finish;
    end
endmodule